// File: doc/BRIEF.md
# DMA Channel Request Arbiter

This block decides which of sixteen DMA channels a single transfer engine serves next. Each channel offers a request line, a 4-bit priority level and a bit that allows it to be preempted. A mode input selects fixed-priority selection, where the highest level wins, or round-robin selection, which walks the channels from the top number downward and ignores levels.

A grant is issued only while the engine is idle. It is then held until the engine reports completion with a done pulse. On completion the arbiter acknowledges the request of the channel it served. Error pulses from the engine are steered to the same channel. In fixed mode a running channel that allows preemption gives way to a requester with a strictly higher level, and the arbiter flags that event with a one-cycle pulse. All outputs come from registers.

Top module: `dma_chan_arbiter`

## Requirements
- R1: After reset, grant_valid_o, grant_o, preempt_o, ack_o and err_irq_o are all zero, and err_chan_o is 0.
- R2: In fixed mode (rr_mode_i = 0 when the grant is made), the grant goes to the requesting channel with the numerically largest level on prio_i. Channel n's level is bits [4n+3:4n].
- R3: In fixed mode, when several requesting channels share the largest level, the lowest-numbered one among them is granted.
- R4: In round-robin mode (rr_mode_i = 1 when the grant is made), the grant goes to the first requesting channel found scanning downward from the last granted channel minus one, wrapping from 0 to 15. Levels are ignored, the first scan after reset starts at channel 15, and every grant in either mode updates the last-granted record.
- R5: A grant appears on the clock edge after requests are seen while idle. It is held unchanged until done_i, apart from preemption. grant_valid_o drops on the edge after done_i, so a new grant comes at the earliest one edge later.
- R6: In fixed mode, when the granted channel has preempt_en_i set and a requester has a strictly higher level, the next edge grants that requester and preempt_o pulses high for one cycle. An equal level does not preempt.
- R7: A channel granted in round-robin mode is never preempted. preempt_o stays low and the grant holds until done_i.
- R8: The mode is taken from rr_mode_i only when a grant is made. Changing rr_mode_i during a transfer does not alter how that transfer is handled.
- R9: done_i while a grant is valid makes ack_o a one-cycle one-hot pulse on the granted channel on the next edge. Otherwise ack_o is zero.
- R10: err_i while a grant is valid makes err_irq_o a one-cycle one-hot pulse on the granted channel on the next edge. err_chan_o takes that channel number and holds it until the next error.
- R11: While grant_valid_o is high, grant_o is one-hot with its set bit at grant_id_o. While grant_valid_o is low, grant_o is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_i | input | 16 | Per-channel service request |
| prio_i | input | 64 | Per-channel 4-bit levels, channel n in bits [4n+3:4n] |
| preempt_en_i | input | 16 | Per-channel permission to be preempted |
| rr_mode_i | input | 1 | 1 selects round-robin, 0 selects fixed priority |
| done_i | input | 1 | Engine finished the granted channel |
| err_i | input | 1 | Engine error during the granted channel |
| grant_o | output | 16 | One-hot grant |
| grant_id_o | output | 4 | Granted channel number |
| grant_valid_o | output | 1 | A channel is granted |
| preempt_o | output | 1 | One-cycle preemption flag |
| ack_o | output | 16 | One-hot request acknowledge on completion |
| err_irq_o | output | 16 | One-hot error interrupt pulse |
| err_chan_o | output | 4 | Channel of the most recent error |

## Verification
All results are due exactly one clock edge after the inputs that cause them: a grant from idle, a preemption switch, the release after done_i, and the acknowledge and error pulses. A new grant after a completion therefore comes two edges after the done pulse. The bench holds a model that advances one edge per step from the inputs applied before that edge. It compares every output one nanosecond after the edge, so no check reads a value that is still changing. Directed sequences cover ties, the round-robin start and wrap, equal and higher-level preemption, and a mode switch mid-transfer. Seeded random traffic follows them.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;

    typedef enum logic {
        ARB_FIXED = 1'b0,
        ARB_RR    = 1'b1
    } arb_mode_e;

endpackage

// File: rtl/dma_arb_fixed_pick.sv
module dma_arb_fixed_pick #(
    parameter int NUM_CH = 16,
    parameter int PRIO_W = 4,
    localparam int ID_W  = $clog2(NUM_CH)
) (
    input  logic [NUM_CH-1:0]        req,
    input  logic [NUM_CH*PRIO_W-1:0] prio,
    output logic                     found,
    output logic [ID_W-1:0]          id,
    output logic [PRIO_W-1:0]        lvl
);

    logic [PRIO_W-1:0] lvl_a [NUM_CH];

    for (genvar g = 0; g < NUM_CH; g++) begin : g_unpack
        assign lvl_a[g] = prio[g*PRIO_W +: PRIO_W];
    end

    // Scan from the top so that ">=" lets lower numbers win ties.
    always_comb begin
        found = 1'b0;
        id    = '0;
        lvl   = '0;
        for (int i = NUM_CH - 1; i >= 0; i--) begin
            if (req[i] && (!found || lvl_a[i] >= lvl)) begin
                found = 1'b1;
                id    = ID_W'(i);
                lvl   = lvl_a[i];
            end
        end
    end

endmodule

// File: rtl/dma_arb_rr_pick.sv
module dma_arb_rr_pick #(
    parameter int NUM_CH = 16,
    localparam int ID_W  = $clog2(NUM_CH)
) (
    input  logic [NUM_CH-1:0] req,
    input  logic [ID_W-1:0]   last,
    output logic              found,
    output logic [ID_W-1:0]   id
);

    // Downward scan starting one below the last granted channel.
    always_comb begin
        found = 1'b0;
        id    = '0;
        for (int k = 1; k <= NUM_CH; k++) begin
            int idx;
            idx = (int'(last) + NUM_CH - k) % NUM_CH;
            if (!found && req[idx]) begin
                found = 1'b1;
                id    = ID_W'(idx);
            end
        end
    end

endmodule

// File: rtl/dma_chan_arbiter.sv
module dma_chan_arbiter
    import dma_arb_pkg::*;
#(
    parameter int NUM_CH = 16,
    parameter int PRIO_W = 4,
    localparam int ID_W  = $clog2(NUM_CH)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NUM_CH-1:0]        req_i,
    input  logic [NUM_CH*PRIO_W-1:0] prio_i,
    input  logic [NUM_CH-1:0]        preempt_en_i,
    input  logic                     rr_mode_i,
    input  logic                     done_i,
    input  logic                     err_i,
    output logic [NUM_CH-1:0]        grant_o,
    output logic [ID_W-1:0]          grant_id_o,
    output logic                     grant_valid_o,
    output logic                     preempt_o,
    output logic [NUM_CH-1:0]        ack_o,
    output logic [NUM_CH-1:0]        err_irq_o,
    output logic [ID_W-1:0]          err_chan_o
);

    localparam logic [NUM_CH-1:0] ONE = NUM_CH'(1);

    typedef struct packed {
        logic              valid;
        logic [ID_W-1:0]   id;
        logic [NUM_CH-1:0] gnt;
        arb_mode_e         mode;
        logic [ID_W-1:0]   last;
        logic              preempt;
        logic [NUM_CH-1:0] ack;
        logic [NUM_CH-1:0] err;
        logic [ID_W-1:0]   err_ch;
    } arb_state_t;

    arb_state_t st_d, st_q;

    logic              fix_found, rr_found;
    logic [ID_W-1:0]   fix_id, rr_id;
    logic [PRIO_W-1:0] fix_lvl, cur_lvl;
    logic              run_rr;

    dma_arb_fixed_pick #(.NUM_CH(NUM_CH), .PRIO_W(PRIO_W)) u_fixed (
        .req   (req_i),
        .prio  (prio_i),
        .found (fix_found),
        .id    (fix_id),
        .lvl   (fix_lvl)
    );

    dma_arb_rr_pick #(.NUM_CH(NUM_CH)) u_rr (
        .req   (req_i),
        .last  (st_q.last),
        .found (rr_found),
        .id    (rr_id)
    );

    assign cur_lvl = prio_i[st_q.id*PRIO_W +: PRIO_W];
    assign run_rr  = (st_q.mode == ARB_RR);

    always_comb begin
        st_d         = st_q;
        st_d.preempt = 1'b0;
        st_d.ack     = '0;
        st_d.err     = '0;

        if (st_q.valid) begin
            if (err_i) begin
                st_d.err[st_q.id] = 1'b1;
                st_d.err_ch       = st_q.id;
            end
            if (done_i) begin
                st_d.ack[st_q.id] = 1'b1;
                st_d.valid        = 1'b0;
                st_d.gnt          = '0;
            end else if (st_q.mode == ARB_FIXED && preempt_en_i[st_q.id]
                         && fix_found && (fix_lvl > cur_lvl)) begin
                st_d.id      = fix_id;
                st_d.gnt     = ONE << fix_id;
                st_d.last    = fix_id;
                st_d.preempt = 1'b1;
            end
        end else if (rr_mode_i) begin
            if (rr_found) begin
                st_d.valid = 1'b1;
                st_d.id    = rr_id;
                st_d.gnt   = ONE << rr_id;
                st_d.last  = rr_id;
                st_d.mode  = ARB_RR;
            end
        end else if (fix_found) begin
            st_d.valid = 1'b1;
            st_d.id    = fix_id;
            st_d.gnt   = ONE << fix_id;
            st_d.last  = fix_id;
            st_d.mode  = ARB_FIXED;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign grant_o       = st_q.gnt;
    assign grant_id_o    = st_q.id;
    assign grant_valid_o = st_q.valid;
    assign preempt_o     = st_q.preempt;
    assign ack_o         = st_q.ack;
    assign err_irq_o     = st_q.err;
    assign err_chan_o    = st_q.err_ch;

endmodule

// File: rtl/dma_arb_checker.sv
module dma_arb_checker #(
    parameter int NUM_CH = 16,
    localparam int ID_W  = $clog2(NUM_CH)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              done_i,
    input logic              err_i,
    input logic [NUM_CH-1:0] grant_o,
    input logic [ID_W-1:0]   grant_id_o,
    input logic              grant_valid_o,
    input logic              preempt_o,
    input logic [NUM_CH-1:0] ack_o,
    input logic [NUM_CH-1:0] err_irq_o,
    input logic              run_rr
);

    assert_grant_shape_R11: assert property (@(posedge clk) disable iff (!rst_n)
        grant_valid_o |-> ($onehot(grant_o) && grant_o[grant_id_o]));

    assert_grant_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !grant_valid_o |-> (grant_o == '0));

    assert_grant_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_valid_o && !done_i) |=> grant_valid_o);

    assert_grant_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_valid_o && done_i) |=> !grant_valid_o);

    assert_preempt_switch_R6: assert property (@(posedge clk) disable iff (!rst_n)
        preempt_o |-> (grant_valid_o && grant_id_o != $past(grant_id_o)));

    assert_rr_no_preempt_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (run_rr && grant_valid_o && !done_i) |=> (!preempt_o && $stable(grant_id_o)));

    assert_ack_target_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_valid_o && done_i) |=> ack_o[$past(grant_id_o)]);

    assert_ack_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(ack_o) <= 1);

    assert_err_target_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_valid_o && err_i) |=> ($onehot(err_irq_o) && err_irq_o[$past(grant_id_o)]));

endmodule

bind dma_chan_arbiter dma_arb_checker #(.NUM_CH(NUM_CH)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .done_i        (done_i),
    .err_i         (err_i),
    .grant_o       (grant_o),
    .grant_id_o    (grant_id_o),
    .grant_valid_o (grant_valid_o),
    .preempt_o     (preempt_o),
    .ack_o         (ack_o),
    .err_irq_o     (err_irq_o),
    .run_rr        (run_rr)
);

// File: tb/test_dma_chan_arbiter.sv
`timescale 1ns/1ps
module test_dma_chan_arbiter;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] req = '0;
    logic [63:0] prio = '0;
    logic [15:0] pe = '0;
    logic        rr = 1'b0;
    logic        done = 1'b0;
    logic        err = 1'b0;
    logic [15:0] grant_o, ack_o, err_irq_o;
    logic [3:0]  grant_id_o, err_chan_o;
    logic        grant_valid_o, preempt_o;

    int n_checks = 0;
    int n_errors = 0;

    bit        m_valid = 0;
    bit        m_rr = 0;
    int        m_id = 0;
    int        m_last = 0;
    bit        e_pre = 0;
    bit [15:0] e_ack = '0;
    bit [15:0] e_err = '0;
    int        e_errch = 0;

    always #2.5 clk = ~clk;

    dma_chan_arbiter i_dma_chan_arbiter (
        .clk(clk), .rst_n(rst_n), .req_i(req), .prio_i(prio),
        .preempt_en_i(pe), .rr_mode_i(rr), .done_i(done), .err_i(err),
        .grant_o(grant_o), .grant_id_o(grant_id_o), .grant_valid_o(grant_valid_o),
        .preempt_o(preempt_o), .ack_o(ack_o), .err_irq_o(err_irq_o),
        .err_chan_o(err_chan_o)
    );

    function automatic int lvl(input int ch);
        return int'(prio[ch*4 +: 4]);
    endfunction

    function automatic int fix_pick();
        int best = -1;
        for (int i = 0; i < 16; i++)
            if (req[i] && (best < 0 || lvl(i) > lvl(best))) best = i;
        return best;
    endfunction

    function automatic int rr_pick();
        for (int k = 1; k <= 16; k++) begin
            int idx = (m_last + 16 - k) % 16;
            if (req[idx]) return idx;
        end
        return -1;
    endfunction

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic step();
        int f = fix_pick();
        int r = rr_pick();
        bit n_valid = m_valid;
        bit n_rr = m_rr;
        int n_id = m_id;
        int n_last = m_last;
        bit n_pre = 0;
        bit [15:0] n_ack = '0;
        bit [15:0] n_err = '0;
        int n_errch = e_errch;
        if (m_valid) begin
            if (err) begin n_err[m_id] = 1'b1; n_errch = m_id; end
            if (done) begin
                n_ack[m_id] = 1'b1;
                n_valid = 0;
            end else if (!m_rr && pe[m_id] && f >= 0 && lvl(f) > lvl(m_id)) begin
                n_id = f; n_last = f; n_pre = 1;
            end
        end else if (rr) begin
            if (r >= 0) begin n_valid = 1; n_id = r; n_last = r; n_rr = 1; end
        end else if (f >= 0) begin
            n_valid = 1; n_id = f; n_last = f; n_rr = 0;
        end
        @(posedge clk);
        #1;
        m_valid = n_valid; m_rr = n_rr; m_id = n_id; m_last = n_last;
        e_pre = n_pre; e_ack = n_ack; e_err = n_err; e_errch = n_errch;
        chk(32'(grant_valid_o), 32'(m_valid), "R5 valid");
        if (m_valid) chk(32'(grant_id_o), 32'(m_id), m_rr ? "R4 id" : "R2 id");
        chk(32'(grant_o), m_valid ? (32'd1 << m_id) : 32'd0, "R11 onehot");
        chk(32'(preempt_o), 32'(e_pre), m_rr ? "R7 preempt" : "R6 preempt");
        chk(32'(ack_o), 32'(e_ack), "R9 ack");
        chk(32'(err_irq_o), 32'(e_err), "R10 irq");
        chk(32'(err_chan_o), 32'(e_errch), "R10 chan");
    endtask

    task automatic finish_xfer();
        done = 1'b1; step(); done = 1'b0;
        req = '0; step();
    endtask

    function automatic void set_lvl(input int ch, input int v);
        prio[ch*4 +: 4] = 4'(v);
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        n_errors++;
        $display("FAIL R5: watchdog expired actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        chk(32'(grant_valid_o), 0, "R1 valid");
        chk(32'(grant_o), 0, "R1 grant");
        chk(32'(preempt_o | (|ack_o) | (|err_irq_o)), 0, "R1 pulses");
        chk(32'(err_chan_o), 0, "R1 chan");

        // R4: first scan after reset starts at 15, levels ignored, wraps
        rr = 1'b1; set_lvl(2, 15);
        req = 16'b1100_0000_0000_0100;
        step(); chk(32'(grant_id_o), 15, "R4 first");
        done = 1'b1; step(); done = 1'b0;
        step(); chk(32'(grant_id_o), 14, "R4 next");
        done = 1'b1; step(); done = 1'b0;
        step(); chk(32'(grant_id_o), 2, "R4 skip");
        done = 1'b1; step(); done = 1'b0;
        step(); chk(32'(grant_id_o), 15, "R4 wrap");
        finish_xfer();

        // R2 and R3: highest level wins, ties go low
        rr = 1'b0; prio = '0;
        set_lvl(3, 5); set_lvl(7, 9); set_lvl(9, 9);
        req = (16'd1 << 3) | (16'd1 << 7) | (16'd1 << 9);
        step(); chk(32'(grant_id_o), 7, "R3 tie");
        finish_xfer();

        // R6: equal level keeps, higher level preempts
        prio = '0; pe = 16'd1 << 4; set_lvl(4, 3);
        req = 16'd1 << 4; step();
        chk(32'(grant_id_o), 4, "R2 single");
        set_lvl(10, 3); req = (16'd1 << 4) | (16'd1 << 10);
        step(); chk(32'(grant_id_o), 4, "R6 equal");
        set_lvl(10, 8);
        step(); chk(32'(grant_id_o), 10, "R6 switch");
        chk(32'(preempt_o), 1, "R6 pulse");
        step(); chk(32'(preempt_o), 0, "R6 one cycle");
        finish_xfer();

        // R7: round-robin grant is never preempted
        rr = 1'b1; prio = '0; pe = '1;
        req = 16'd1 << 5; step();
        set_lvl(12, 15); req = (16'd1 << 5) | (16'd1 << 12);
        step(); step();
        chk(32'(grant_id_o), 5, "R7 hold");
        chk(32'(preempt_o), 0, "R7 no pulse");
        finish_xfer();

        // R8: mode switched mid-transfer does not apply until next grant
        rr = 1'b0; prio = '0; pe = 16'd1 << 1; set_lvl(1, 1);
        req = 16'd1 << 1; step();
        rr = 1'b1; set_lvl(6, 9); req = (16'd1 << 1) | (16'd1 << 6);
        step(); chk(32'(preempt_o), 1, "R8 still fixed");
        chk(32'(grant_id_o), 6, "R8 id");
        finish_xfer();

        // R9 and R10: acknowledge and error steering
        rr = 1'b0; prio = '0; req = 16'd1 << 3; step();
        err = 1'b1; step(); err = 1'b0;
        chk(32'(err_irq_o), 32'd1 << 3, "R10 irq dir");
        chk(32'(err_chan_o), 3, "R10 chan dir");
        done = 1'b1; step(); done = 1'b0;
        chk(32'(ack_o), 32'd1 << 3, "R9 ack dir");
        req = '0; step();

        // Seeded random traffic
        for (int c = 0; c < 3000; c++) begin
            if (c % 64 == 0) begin
                prio = {$urandom(), $urandom()};
                pe = 16'($urandom());
            end
            if (c % 37 == 0) rr = 1'($urandom() % 2);
            req  = 16'($urandom() & $urandom());
            done = m_valid && ($urandom() % 4 == 0);
            err  = m_valid && ($urandom() % 8 == 0);
            step();
        end
        done = 1'b0; err = 1'b0;

        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule